// File: doc/BRIEF.md
# Synchronous answer-to-reset serializer

This block sends a fixed 32-bit identification word on a single serial data line whenever the host strobes the reset input while the device is selected. It is meant for a smart-card style serial memory. The bit order is least significant bit first within each byte, and the bytes go out in order from byte 0 to byte 3. The default word holds the bytes 0x19, 0x00, 0xAA and 0x55. The first bit appears once the reset strobe has fallen. Each falling edge of the serial clock then moves the line to the next bit. The host can therefore sample on the rising edge. If the host keeps clocking past the 32nd bit, the same word is sent again from byte 0 bit 0, with no limit.

All inputs are taken as synchronous to the system clock `clk`, and the block finds edges on the reset strobe and on the serial clock itself. The response does not start when a nonvolatile write is in progress. It also does not start when the chip is not selected. Raising chip select ends the response at once and returns the block to standby. A reset strobe that arrives during an ordinary two-wire transaction ends that transaction. The data output then stays released until the command decoder reports a stop condition. In standby the output enable is low, so the line floats.

Top module: `atr_top`

## Requirements
- R1: After the asynchronous reset `rstN` is released, `respActive` and `sdoOe` are 0, and they stay 0 until a response is started.
- R2: A falling edge of `rstPulse` starts a response in the next `clk` cycle, making `respActive` and `sdoOe` 1 and placing bit 0 of the word on `sdo`. Every one of these conditions must hold in the cycle of that falling edge: `csN` = 0, `wrBusy` = 0, `busTxn` = 0, and no stop is pending.
- R3: While a response is active, each falling edge of `sck` advances `sdo` to the next bit in the cycle that follows. Bit k of the 32-bit stream is bit (k mod 8) of byte (k div 8), and the bytes are 0x19, 0x00, 0xAA, 0x55 for bytes 0 to 3. The stream therefore begins 1,0,0,1,1,0,0,0.
- R4: The falling `sck` edge after bit 31 returns the stream to bit 0 of byte 0, and this wrap repeats without limit.
- R5: `csN` = 1 in any cycle ends the response in the next cycle, with `respActive` and `sdoOe` both 0. Later `sck` edges do not restart it.
- R6: A falling edge of `rstPulse` while `wrBusy` = 1 starts no response, so `sdoOe` stays 0.
- R7: A falling edge of `rstPulse` while `csN` = 1 starts no response.
- R8: A falling edge of `rstPulse` while `busTxn` = 1 ends any active response and releases `sdoOe`. No response can start after that until a cycle with `busStop` = 1 has been seen. The first strobe after the stop starts one normally.
- R9: A falling edge of `rstPulse` during an active response restarts the stream at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rstPulse | input | 1 | Reset strobe; its falling edge triggers the response |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock; its falling edge advances the bit |
| wrBusy | input | 1 | Nonvolatile write in progress |
| busTxn | input | 1 | Two-wire transaction in progress (from the command decoder) |
| busStop | input | 1 | Stop condition seen (one-cycle strobe from the decoder) |
| sdo | output | 1 | Serial response bit |
| sdoOe | output | 1 | Output enable for the serial data driver |
| respActive | output | 1 | A response is in progress |

## Verification
The bench targets these corner cases:
- The exact bit order through byte 0. A design that sent the most significant bit first would put 0 on the line instead of 1 right after the strobe.
- The wrap from bit 31 back to bit 0. A counter that overran or stuck would repeat 0x55 bits or fall out of step with the model.
- Strobes issued while a write is busy, while the chip is deselected, and during a bus transaction. Any of these that leaked through would turn on the output enable when it should stay off.
- A lock after a mid-transaction strobe that never cleared on the stop condition. It would refuse the response that follows.
- A restart in the middle of the stream that failed to reset the position. It would carry on from the old bit.

// File: rtl/atr_pkg.sv
package atr_pkg;
  localparam int RESP_LEN = 32;
  localparam int IDX_W    = $clog2(RESP_LEN);

  typedef struct packed {
    logic start;
    logic advance;
    logic clear;
  } seqStrobe_t;
endpackage

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstPulse,
  input  logic       csN,
  input  logic       sck,
  input  logic       wrBusy,
  input  logic       busTxn,
  input  logic       busStop,
  output seqStrobe_t strb,
  output logic       active,
  output logic       locked
);
  logic rstQ;
  logic sckQ;
  logic fallRst;
  logic fallSck;
  logic txnKill;

  assign fallRst = rstQ & ~rstPulse;
  assign fallSck = sckQ & ~sck;
  assign txnKill = fallRst & busTxn;

  always_comb begin
    strb.clear   = csN | txnKill;
    strb.start   = ~strb.clear & fallRst & ~wrBusy & ~locked;
    strb.advance = ~strb.clear & ~strb.start & active & fallSck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstQ   <= 1'b0;
      sckQ   <= 1'b0;
      active <= 1'b0;
      locked <= 1'b0;
    end else begin
      rstQ   <= rstPulse;
      sckQ   <= sck;
      locked <= txnKill | (locked & ~busStop);
      if (strb.clear)      active <= 1'b0;
      else if (strb.start) active <= 1'b1;
    end
  end
endmodule

// File: rtl/atr_dp.sv
module atr_dp
  import atr_pkg::*;
#(
  parameter logic [RESP_LEN-1:0] RESP_WORD = 32'h55AA0019
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             active,
  output logic             sdo,
  output logic [IDX_W-1:0] bitIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RESP_LEN - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= '0;
    end else if (strb.clear || strb.start) begin
      bitIdx <= '0;
    end else if (strb.advance) begin
      bitIdx <= (bitIdx == LAST_IDX) ? '0 : bitIdx + 1'b1;
    end
  end

  assign sdo = active & RESP_WORD[bitIdx];
endmodule

// File: rtl/atr_top.sv
module atr_top
  import atr_pkg::*;
#(
  parameter logic [RESP_LEN-1:0] RESP_WORD = 32'h55AA0019
) (
  input  logic clk,
  input  logic rstN,
  input  logic rstPulse,
  input  logic csN,
  input  logic sck,
  input  logic wrBusy,
  input  logic busTxn,
  input  logic busStop,
  output logic sdo,
  output logic sdoOe,
  output logic respActive
);
  seqStrobe_t       strb;
  logic             active;
  logic             locked;
  logic [IDX_W-1:0] bitIdx;

  atr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rstPulse(rstPulse), .csN(csN), .sck(sck),
    .wrBusy(wrBusy), .busTxn(busTxn), .busStop(busStop),
    .strb(strb), .active(active), .locked(locked)
  );

  atr_dp #(.RESP_WORD(RESP_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .active(active),
    .sdo(sdo), .bitIdx(bitIdx)
  );

  assign sdoOe      = active;
  assign respActive = active;
endmodule

// File: rtl/atr_chk.sv
module atr_chk
  import atr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             wrBusy,
  input logic             busStop,
  input logic             sdoOe,
  input logic             respActive,
  input logic             locked,
  input seqStrobe_t       strb,
  input logic [IDX_W-1:0] bitIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RESP_LEN - 1);

  a_r5_cs_abort: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !respActive);

  a_r6_busy_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (wrBusy && !respActive) |=> !respActive);

  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (bitIdx == '0 && respActive));

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && bitIdx != LAST_IDX) |=> bitIdx == IDX_W'($past(bitIdx) + 1'b1));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && bitIdx == LAST_IDX) |=> bitIdx == '0);

  a_r8_locked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !busStop) |=> !sdoOe);
endmodule

bind atr_top atr_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .wrBusy(wrBusy), .busStop(busStop),
  .sdoOe(sdoOe), .respActive(respActive), .locked(locked),
  .strb(strb), .bitIdx(bitIdx)
);

// File: tb/sim_atr_top.sv
module sim_atr_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rstPulse = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic wrBusy = 1'b0;
  logic busTxn = 1'b0;
  logic busStop = 1'b0;
  logic sdo, sdoOe, respActive;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit done = 1'b0;

  byte unsigned respBytes[$] = '{8'h19, 8'h00, 8'hAA, 8'h55};

  // behavioural reference state
  bit mAct, mLock, mPrevRst, mPrevSck;
  int mPos;

  atr_top u0 (
    .clk(clk), .rstN(rstN), .rstPulse(rstPulse), .csN(csN), .sck(sck),
    .wrBusy(wrBusy), .busTxn(busTxn), .busStop(busStop),
    .sdo(sdo), .sdoOe(sdoOe), .respActive(respActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAct = 0; mLock = 0; mPrevRst = 0; mPrevSck = 0; mPos = 0;
    end else begin
      bit fr, fs, oldLock;
      fr = mPrevRst && !rstPulse;
      fs = mPrevSck && !sck;
      oldLock = mLock;
      mLock = (fr && busTxn) || (mLock && !busStop);
      if (csN || (fr && busTxn)) begin
        mAct = 0; mPos = 0;
      end else if (fr && !wrBusy && !oldLock) begin
        mAct = 1; mPos = 0;
      end else if (mAct && fs) begin
        mPos = (mPos + 1) % 32;
      end
      mPrevRst = rstPulse;
      mPrevSck = sck;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, "sdoOe", sdoOe, mAct);
      check(curReq, "respActive", respActive, mAct);
      if (mAct) check(curReq, "sdo", sdo, respBytes[mPos / 8][mPos % 8]);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic strobeReset();
    rstPulse = 1'b1; tick(2);
    rstPulse = 1'b0; tick(2);
  endtask

  task automatic sckPulses(int n);
    repeat (n) begin
      sck = 1'b1; tick(2);
      sck = 1'b0; tick(2);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    curReq = "R1"; tick(4);
    check("R1", "sdoOe after reset", sdoOe, 1'b0);
    sckPulses(3);

    curReq = "R2"; csN = 1'b0; tick(2);
    strobeReset();
    check("R2", "first bit", sdo, 1'b1);
    curReq = "R3"; sckPulses(31);
    curReq = "R4"; sckPulses(40);

    curReq = "R5"; csN = 1'b1; tick(2);
    check("R5", "sdoOe after deselect", sdoOe, 1'b0);
    sckPulses(4); csN = 1'b0; sckPulses(4);

    curReq = "R6"; wrBusy = 1'b1; strobeReset(); sckPulses(3);
    check("R6", "sdoOe under write", sdoOe, 1'b0);
    wrBusy = 1'b0; tick(2);

    curReq = "R7"; csN = 1'b1; strobeReset(); csN = 1'b0; sckPulses(3);

    curReq = "R9"; strobeReset(); sckPulses(7); strobeReset(); sckPulses(10);

    curReq = "R8"; busTxn = 1'b1; strobeReset(); busTxn = 1'b0; tick(2);
    check("R8", "released after bus strobe", sdoOe, 1'b0);
    strobeReset(); sckPulses(2);
    busStop = 1'b1; tick(1); busStop = 1'b0; tick(2);
    strobeReset(); sckPulses(12);
    busTxn = 1'b1; strobeReset(); busTxn = 1'b0; sckPulses(2);
    busStop = 1'b1; tick(1); busStop = 1'b0;
    strobeReset(); sckPulses(35);

    tick(4);
    finishRun();
  end
endmodule